// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This unit sits between a processor core and a data memory that is one 32-bit word wide. For each request it takes a memory opcode, a base register value, a 17-bit immediate and the value to be stored. It then produces the word-aligned memory address, four byte write enables and the write data. When read data comes back, it turns that data into the value the register file should receive.

Both word and byte accesses are supported. The effective address is `base + 4*imm` for words and `base + imm` for bytes, and the immediate is sign-extended first. The two low address bits choose a byte lane. Lanes are numbered big-endian: lane 0 is bits 31:24 and lane 3 is bits 7:0.

The request is registered, so the memory command appears one clock after the request. Formatted load data appears one clock after the memory command, which is two clocks after the request. In the core, the store data value comes from the register named in instruction bits 26-22 and the base comes from the register in bits 21-17. Both reach this block as plain 32-bit values.

Top module: `lsu_lane_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `mem_we` is 0, `mem_re` is 0, `acc_misaligned` is 0, `ld_valid` is 0 and `ld_data` is 0.
- R2: A word access (opcode 10000 = word load, 10010 = word store) addresses `base + 4*imm`. `mem_addr` shows that address with bits 1:0 forced to 0, one cycle after the request.
- R3: A byte access (opcode 10001 = byte load, 10011 = byte store) addresses `base + imm`. `mem_addr` shows that address with bits 1:0 cleared, and bits 1:0 select the lane.
- R4: The 17-bit immediate is sign-extended before the add. For example, 0x1FFFF adds -1 for a byte access and -4 for a word access.
- R5: An aligned word store drives `mem_we` = 4'b1111 and `mem_wdata` = the store data.
- R6: A byte store asserts exactly one enable: lane L drives `mem_we[3-L]`, so lane 0 gives 4'b1000 and lane 3 gives 4'b0001. The low 8 bits of the store data are replicated into all four bytes of `mem_wdata`, and the upper 24 bits are discarded.
- R7: An aligned word load raises `mem_re` one cycle after the request. One cycle after that, `ld_valid` is 1 and `ld_data` equals `mem_rdata`.
- R8: A byte load returns the selected lane, where lane 0 is `mem_rdata[31:24]`, sign-extended to 32 bits.
- R9: A word access whose effective address has nonzero bits 1:0 raises `acc_misaligned` for one cycle, with `mem_we` = 0 and `mem_re` = 0, and it produces no `ld_valid`. Memory is left unchanged. Byte accesses are never misaligned.
- R10: A cycle with `req_valid` low, or with any other opcode, produces no write, no read and no misaligned flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 5 | Primary opcode of the request |
| req_base | input | 32 | Base register value |
| req_imm | input | 17 | Immediate field |
| req_sdata | input | 32 | Store source register value |
| mem_rdata | input | 32 | Word read from memory at `mem_addr` |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_we | output | 4 | Byte write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Write data, lane-steered |
| mem_re | output | 1 | Read command |
| acc_misaligned | output | 1 | Misaligned word access flag |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Formatted load result |

## Verification
Errors in the registered lane select or the byte flag do not show up when the command is issued. They show up one cycle later, as a wrong byte or a wrong sign extension in `ld_data`, so the bench checks byte loads from every lane, with both positive and negative bytes. A wrong enable or a wrong address in the command stage shows up in the very next cycle on `mem_we` and `mem_addr`. It also persists as corrupted memory, which later word loads read back. A misaligned store that leaks through would only be seen through a follow-up load of the same word.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam int LSU_DW    = 32;
    localparam int LSU_LANES = LSU_DW / 8;
    localparam int LSU_LSELW = $clog2(LSU_LANES);

    typedef enum logic [4:0] {
        OP_LDW = 5'b10000,
        OP_LDB = 5'b10001,
        OP_STW = 5'b10010,
        OP_STB = 5'b10011
    } lsu_op_e;

    typedef struct packed {
        logic [LSU_DW-1:0]    addr;
        logic [LSU_LANES-1:0] we;
        logic [LSU_DW-1:0]    wdata;
        logic                 re;
        logic                 misal;
        logic [LSU_LSELW-1:0] lane;
        logic                 is_byte;
        logic                 ld_valid;
        logic [LSU_DW-1:0]    ld_data;
    } lsu_state_t;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
    parameter int DW    = 32,
    parameter int IMM_W = 17,
    parameter int LSELW = 2
) (
    input  logic [DW-1:0]    base,
    input  logic [IMM_W-1:0] imm,
    input  logic             is_word,
    output logic [DW-1:0]    eff
);
    logic [DW-1:0] imm_sx;
    logic [DW-1:0] offs;

    always_comb begin
        imm_sx = {{(DW-IMM_W){imm[IMM_W-1]}}, imm};
        offs   = is_word ? (imm_sx << LSELW) : imm_sx;
        eff    = base + offs;
    end
endmodule

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer #(
    parameter int DW    = 32,
    parameter int LANES = 4,
    parameter int LSELW = 2
) (
    input  logic             do_store,
    input  logic             is_byte,
    input  logic [LSELW-1:0] lane,
    input  logic [DW-1:0]    sdata,
    output logic [LANES-1:0] we,
    output logic [DW-1:0]    wdata
);
    // Lane 0 is the most significant byte, driven by enable LANES-1.
    for (genvar i = 0; i < LANES; i++) begin : g_en
        assign we[i] = do_store & (~is_byte | (lane == LSELW'(LANES-1-i)));
    end

    assign wdata = is_byte ? {LANES{sdata[7:0]}} : sdata;
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt #(
    parameter int DW    = 32,
    parameter int LANES = 4,
    parameter int LSELW = 2
) (
    input  logic [DW-1:0]    word,
    input  logic [LSELW-1:0] lane,
    input  logic             is_byte,
    output logic [DW-1:0]    result
);
    logic [7:0] lane_b [LANES];
    logic [7:0] pick;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_b[k] = word[DW-1-8*k -: 8];
    end

    always_comb begin
        pick   = lane_b[lane];
        result = is_byte ? {{(DW-8){pick[7]}}, pick} : word;
    end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_pkg::*;
#(
    parameter int IMM_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [4:0]        req_op,
    input  logic [LSU_DW-1:0] req_base,
    input  logic [IMM_W-1:0]  req_imm,
    input  logic [LSU_DW-1:0] req_sdata,
    input  logic [LSU_DW-1:0] mem_rdata,
    output logic [LSU_DW-1:0] mem_addr,
    output logic [LSU_LANES-1:0] mem_we,
    output logic [LSU_DW-1:0] mem_wdata,
    output logic              mem_re,
    output logic              acc_misaligned,
    output logic              ld_valid,
    output logic [LSU_DW-1:0] ld_data
);
    lsu_state_t st_d, st_q;

    logic is_ld, is_st, is_word, is_byte, acc, misal, ok;
    logic [LSU_DW-1:0]    eff;
    logic [LSU_LANES-1:0] we_c;
    logic [LSU_DW-1:0]    wdata_c;
    logic [LSU_DW-1:0]    fmt_c;

    always_comb begin
        is_ld   = (req_op == OP_LDW) | (req_op == OP_LDB);
        is_st   = (req_op == OP_STW) | (req_op == OP_STB);
        is_word = (req_op == OP_LDW) | (req_op == OP_STW);
        is_byte = (req_op == OP_LDB) | (req_op == OP_STB);
        acc     = req_valid & (is_ld | is_st);
        misal   = acc & is_word & (eff[LSU_LSELW-1:0] != '0);
        ok      = acc & ~misal;
    end

    lsu_addr_gen #(.DW(LSU_DW), .IMM_W(IMM_W), .LSELW(LSU_LSELW)) u_agen (
        .base    (req_base),
        .imm     (req_imm),
        .is_word (is_word),
        .eff     (eff)
    );

    lsu_lane_steer #(.DW(LSU_DW), .LANES(LSU_LANES), .LSELW(LSU_LSELW)) u_steer (
        .do_store (ok & is_st),
        .is_byte  (is_byte),
        .lane     (eff[LSU_LSELW-1:0]),
        .sdata    (req_sdata),
        .we       (we_c),
        .wdata    (wdata_c)
    );

    lsu_load_fmt #(.DW(LSU_DW), .LANES(LSU_LANES), .LSELW(LSU_LSELW)) u_fmt (
        .word    (mem_rdata),
        .lane    (st_q.lane),
        .is_byte (st_q.is_byte),
        .result  (fmt_c)
    );

    always_comb begin
        st_d          = st_q;
        st_d.addr     = {eff[LSU_DW-1:LSU_LSELW], {LSU_LSELW{1'b0}}};
        st_d.we       = we_c;
        st_d.wdata    = wdata_c;
        st_d.re       = ok & is_ld;
        st_d.misal    = misal;
        st_d.lane     = eff[LSU_LSELW-1:0];
        st_d.is_byte  = is_byte;
        st_d.ld_valid = st_q.re;
        st_d.ld_data  = st_q.re ? fmt_c : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_addr       = st_q.addr;
    assign mem_we         = st_q.we;
    assign mem_wdata      = st_q.wdata;
    assign mem_re         = st_q.re;
    assign acc_misaligned = st_q.misal;
    assign ld_valid       = st_q.ld_valid;
    assign ld_data        = st_q.ld_data;
endmodule

// File: rtl/lsu_lane_checker.sv
module lsu_lane_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [4:0]  req_op,
    input logic [31:0] req_base,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_we,
    input logic [31:0] mem_wdata,
    input logic        mem_re,
    input logic        acc_misaligned,
    input logic        ld_valid
);
    // R6 / R5: enables are none, exactly one, or all four
    p_we_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(mem_we) == 0) || ($countones(mem_we) == 1) || ($countones(mem_we) == 4));

    p_byte_replicate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(mem_we) == 1) |->
            (mem_wdata[31:24] == mem_wdata[7:0]) && (mem_wdata[23:16] == mem_wdata[7:0])
            && (mem_wdata[15:8] == mem_wdata[7:0]));

    p_aligned_word_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 5'b10010 && req_base[1:0] == 2'b00) |=> (mem_we == 4'hF));

    p_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we != 4'h0) |-> (mem_addr[1:0] == 2'b00));

    p_ld_follows_re_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> ld_valid);

    p_ld_needs_re_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_re));

    p_misal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_misaligned |-> (mem_we == 4'h0) && !mem_re);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (mem_we == 4'h0) && !mem_re && !acc_misaligned);
endmodule

bind lsu_lane_unit lsu_lane_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_op         (req_op),
    .req_base       (req_base),
    .mem_addr       (mem_addr),
    .mem_we         (mem_we),
    .mem_wdata      (mem_wdata),
    .mem_re         (mem_re),
    .acc_misaligned (acc_misaligned),
    .ld_valid       (ld_valid)
);

// File: tb/sim_lsu_lane_unit.sv
`timescale 1ns/1ps
module sim_lsu_lane_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_op = '0;
    logic [31:0] req_base = '0;
    logic [16:0] req_imm = '0;
    logic [31:0] req_sdata = '0;
    logic [31:0] mem_rdata;
    logic [31:0] mem_addr;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata;
    logic        mem_re;
    logic        acc_misaligned;
    logic        ld_valid;
    logic [31:0] ld_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lsu_lane_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_base(req_base), .req_imm(req_imm), .req_sdata(req_sdata),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_re(mem_re), .acc_misaligned(acc_misaligned),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    // Small word memory model, 16 words
    logic [31:0] mem [16];
    assign mem_rdata = mem[mem_addr[5:2]];
    always @(posedge clk) begin
        for (int k = 0; k < 4; k++)
            if (mem_we[k]) mem[mem_addr[5:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
    end

    typedef struct packed {
        logic [3:0]  rq;
        logic [4:0]  op;
        logic [31:0] base;
        logic [16:0] imm;
        logic [31:0] sd;
        logic [31:0] ea;
        logic [3:0]  ew;
        logic        em;
        logic        ev;
        logic [31:0] ed;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{4'd5, 5'b10010, 32'h0,  17'h0,     32'hDEADBEEF, 32'h0,  4'hF, 1'b0, 1'b0, 32'h0},        // R5
        '{4'd7, 5'b10000, 32'h0,  17'h0,     32'h0,        32'h0,  4'h0, 1'b0, 1'b1, 32'hDEADBEEF}, // R7
        '{4'd8, 5'b10001, 32'h0,  17'h0,     32'h0,        32'h0,  4'h0, 1'b0, 1'b1, 32'hFFFFFFDE}, // R8 lane 0
        '{4'd8, 5'b10001, 32'h0,  17'h3,     32'h0,        32'h0,  4'h0, 1'b0, 1'b1, 32'hFFFFFFEF}, // R8 lane 3
        '{4'd4, 5'b10010, 32'h8,  17'h1FFFF, 32'h12345678, 32'h4,  4'hF, 1'b0, 1'b0, 32'h0},        // R4
        '{4'd8, 5'b10001, 32'h4,  17'h2,     32'h0,        32'h4,  4'h0, 1'b0, 1'b1, 32'h00000056}, // R8 positive
        '{4'd6, 5'b10011, 32'h10, 17'h1,     32'hFFFFFFA5, 32'h10, 4'h4, 1'b0, 1'b0, 32'h0},        // R6 lane 1
        '{4'd6, 5'b10011, 32'h10, 17'h3,     32'h0000003C, 32'h10, 4'h1, 1'b0, 1'b0, 32'h0},        // R6 lane 3
        '{4'd6, 5'b10000, 32'h10, 17'h0,     32'h0,        32'h10, 4'h0, 1'b0, 1'b1, 32'h00A5003C}, // R6 readback
        '{4'd3, 5'b10011, 32'h14, 17'h1FFFC, 32'h00000077, 32'h10, 4'h8, 1'b0, 1'b0, 32'h0},        // R3 lane 0
        '{4'd2, 5'b10000, 32'h4,  17'h3,     32'h0,        32'h10, 4'h0, 1'b0, 1'b1, 32'h77A5003C}, // R2 scale
        '{4'd9, 5'b10010, 32'h2,  17'h1,     32'hCAFEF00D, 32'h4,  4'h0, 1'b1, 1'b0, 32'h0},        // R9 store
        '{4'd9, 5'b10000, 32'h6,  17'h1FFFF, 32'h0,        32'h0,  4'h0, 1'b1, 1'b0, 32'h0},        // R9 load
        '{4'd9, 5'b10000, 32'h4,  17'h0,     32'h0,        32'h4,  4'h0, 1'b0, 1'b1, 32'h12345678}, // R9 untouched
        '{4'd10,5'b00001, 32'h0,  17'h0,     32'h55555555, 32'h0,  4'h0, 1'b0, 1'b0, 32'h0},        // R10 other op
        '{4'd10,5'b10000, 32'h0,  17'h0,     32'h0,        32'h0,  4'h0, 1'b0, 1'b1, 32'hDEADBEEF}  // R10 readback
    };

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic do_req(input logic v, input logic [4:0] op, input logic [31:0] b,
                          input logic [16:0] im, input logic [31:0] sd);
        @(negedge clk);
        req_valid = v; req_op = op; req_base = b; req_imm = im; req_sdata = sd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1 we", {28'h0, mem_we}, 32'h0);
        check("R1 flags", {29'h0, mem_re, acc_misaligned, ld_valid}, 32'h0);
        check("R1 ld_data", ld_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {28'h0, mem_we} | {31'h0, mem_re | ld_valid}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d v%0d", VECS[v].rq, v);
            @(negedge clk);
            req_valid = 1'b1; req_op = VECS[v].op; req_base = VECS[v].base;
            req_imm = VECS[v].imm; req_sdata = VECS[v].sd;
            @(negedge clk);          // command stage registered
            req_valid = 1'b0;
            check({tag, " we"}, {28'h0, mem_we}, {28'h0, VECS[v].ew});
            check({tag, " mis"}, {31'h0, acc_misaligned}, {31'h0, VECS[v].em});
            if (VECS[v].ew != 4'h0 || VECS[v].ev)
                check({tag, " addr"}, mem_addr, VECS[v].ea);
            if (VECS[v].ew != 4'h0 && VECS[v].op == 5'b10011)
                check({tag, " wdata"}, mem_wdata, {4{VECS[v].sd[7:0]}});
            if (VECS[v].ew == 4'hF)
                check({tag, " wdata"}, mem_wdata, VECS[v].sd);
            @(negedge clk);          // load result stage
            check({tag, " ldv"}, {31'h0, ld_valid}, {31'h0, VECS[v].ev});
            if (VECS[v].ev) check({tag, " ld"}, ld_data, VECS[v].ed);
        end

        // R10: store with req_valid low must not write
        do_req(1'b0, 5'b10010, 32'h0, 17'h0, 32'h0BADF00D);
        check("R10 idle we", {28'h0, mem_we}, 32'h0);
        do_req(1'b1, 5'b10000, 32'h0, 17'h0, 32'h0);
        @(negedge clk);
        check("R10 idle store ignored", ld_data, 32'hDEADBEEF);

        // R8: middle lanes of word 0
        do_req(1'b1, 5'b10001, 32'h1, 17'h0, 32'h0);
        @(negedge clk);
        check("R8 lane1", ld_data, 32'hFFFFFFAD);
        do_req(1'b1, 5'b10001, 32'h3, 17'h1FFFF, 32'h0);
        @(negedge clk);
        check("R8 lane2 R4 negative", ld_data, 32'hFFFFFFBE);

        // R1: reset mid-operation clears pending load
        @(negedge clk);
        req_valid = 1'b1; req_op = 5'b10000; req_base = 32'h0; req_imm = 17'h0;
        @(negedge clk);
        req_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears", {28'h0, mem_we} | {29'h0, mem_re, ld_valid, acc_misaligned}, 32'h0);
        check("R1 reset ld_data", ld_data, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule